// File: doc/BRIEF.md
# SIMT Lane Execution Mask Unit

This block holds the execution mask of a 64-lane SIMD group and updates it with scalar mask commands, so that divergent if/else/endif regions and loops with early exits run on one shared instruction stream. Divergence is not tracked by a hardware reconvergence stack. Each command saves a residue mask into a 16-entry scalar mask file. At the join point, that residue is ORed back into the execution mask.

Each command carries an opcode, a 64-bit per-lane condition from the vector compare unit, a read index and a write index into the mask file, a premasked hint for loop-exit updates, and a narrow flag that selects 32-lane operation. A command completes in one clock. On the same edge the block updates the mask, writes the result into the mask file and refreshes two branch-decision flags: "mask empty", used to skip a region, and "mask non-empty", used to take a loop back edge. The program counter logic outside the block uses the flags to make the taken/not-taken decision.

Opcodes on `cmd_op` are: 0 idle, 1 divergent IF, 2 keep-all IF, 3 ELSE, 4 rejoin, 5 loop exit accumulate, 6 loop back, 7 reserved. Below, E is the mask before the command, C is `cond`, and S is mask file entry `rd_idx`.

Top module: `emask_unit`

## Requirements
- R1: After reset the mask is all ones, `br_empty` is 0, `br_nonempty` is 1, `wb_valid` is 0, and every mask file entry reads as zero.
- R2: Opcode 1 (divergent IF) sets the mask to E AND C and writes E AND NOT C (the lanes the condition switched off) into entry `wr_idx`.
- R3: Opcode 2 (keep-all IF) sets the mask to E AND C and writes the full E into entry `wr_idx`.
- R4: Opcode 3 (ELSE) writes E into entry `wr_idx` and sets the mask to (E OR S) XOR E, leaving only the lanes that skipped the THEN part enabled.
- R5: Opcode 4 (rejoin) sets the mask to E OR S and writes nothing.
- R6: Opcode 5 (loop exit accumulate) writes S OR (E AND C) into entry `wr_idx`, or S OR C when `cond_premasked` is 1, and leaves the mask unchanged.
- R7: Opcode 6 (loop back) sets the mask to E AND NOT S and writes nothing. `br_nonempty` then tells whether to branch back.
- R8: From the edge that commits a command, `br_empty` is 1 exactly when the active lanes of the new mask are all zero, and `br_nonempty` is its complement.
- R9: With `cmd_narrow` at 1, only lanes 0 to 31 take part. Mask bits 63:32 keep their values, bits 63:32 of the written value are zero, and the flags test only bits 31:0.
- R10: With `cmd_valid` low, or with opcode 0 or 7, the mask, the flags and the mask file keep their values and `wb_valid` is 0.
- R11: A mask file write is visible on `wb_data` with `wb_valid` high one cycle after the command. The next command that reads that entry sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_narrow | input | 1 | 32-lane mode for this command |
| cond_premasked | input | 1 | Condition already limited to active lanes (opcode 5) |
| cond | input | 64 | Per-lane condition vector |
| rd_idx | input | 4 | Mask file entry read as S |
| wr_idx | input | 4 | Mask file entry written |
| exec_mask | output | 64 | Current lane execution mask |
| wb_valid | output | 1 | A mask file write happened on the last edge |
| wb_data | output | 64 | Value written to the mask file |
| br_empty | output | 1 | Active part of mask is zero |
| br_nonempty | output | 1 | Active part of mask is nonzero |

## Verification
The hardest states to reach from the ports are a nested loop exit that leaves the mask empty and a narrow command that must leave the upper lanes untouched while the flags report an empty mask. The bench reaches the first by accumulating exit lanes over several exit commands and loop back steps until `br_empty` rises. It reaches the second by issuing a narrow IF whose condition clears all low lanes while the upper mask half is still set, and then rejoining in full width. A reference model in the bench follows every command, so the residues stored in the mask file are checked later through the mask changes they cause.

// File: rtl/emask_pkg.sv
package emask_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_IF      = 3'd1,
    OP_IF_KEEP = 3'd2,
    OP_ELSE    = 3'd3,
    OP_REJOIN  = 3'd4,
    OP_EXIT    = 3'd5,
    OP_LOOP    = 3'd6,
    OP_RSVD    = 3'd7
  } mask_op_e;

  localparam int DEF_LANES   = 64;
  localparam int DEF_NARROW  = 32;
  localparam int DEF_ENTRIES = 16;

endpackage

// File: rtl/emask_sgrf.sv
module emask_sgrf #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 64,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDXW-1:0]  waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDXW-1:0]  raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] entry_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry_q[g] <= '0;
      else if (we && (waddr == IDXW'(g)))
        entry_q[g] <= wdata;
    end
  end

  assign rdata = entry_q[raddr];

endmodule

// File: rtl/emask_alu.sv
module emask_alu
  import emask_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int NARROW = 32
) (
  input  mask_op_e         op,
  input  logic             narrow,
  input  logic             premasked,
  input  logic [LANES-1:0] exec_cur,
  input  logic [LANES-1:0] cond,
  input  logic [LANES-1:0] saved,
  output logic [LANES-1:0] exec_nxt,
  output logic             exec_en,
  output logic [LANES-1:0] wb_val,
  output logic             wb_en
);

  function automatic logic [LANES-1:0] lane_window(input logic nar);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = !nar || (i < NARROW);
    return m;
  endfunction

  function automatic logic [LANES-1:0] f_if_mask(input logic [LANES-1:0] e, c);
    return e & c;
  endfunction

  function automatic logic [LANES-1:0] f_residue(input logic [LANES-1:0] e, n);
    return e ^ n;
  endfunction

  function automatic logic [LANES-1:0] f_else_mask(input logic [LANES-1:0] e, s);
    return (e | s) ^ e;
  endfunction

  function automatic logic [LANES-1:0] f_rejoin(input logic [LANES-1:0] e, s);
    return e | s;
  endfunction

  function automatic logic [LANES-1:0] f_exit(input logic [LANES-1:0] e, c, s,
                                              input logic pm);
    return s | (pm ? c : (e & c));
  endfunction

  function automatic logic [LANES-1:0] f_loop(input logic [LANES-1:0] e, s);
    return e & ~s;
  endfunction

  logic [LANES-1:0] win;
  logic [LANES-1:0] raw_exec;
  logic [LANES-1:0] raw_wb;

  assign win = lane_window(narrow);

  always_comb begin
    raw_exec = exec_cur;
    raw_wb   = '0;
    exec_en  = 1'b0;
    wb_en    = 1'b0;
    unique case (op)
      OP_IF: begin
        raw_exec = f_if_mask(exec_cur, cond);
        raw_wb   = f_residue(exec_cur, raw_exec);
        exec_en  = 1'b1;
        wb_en    = 1'b1;
      end
      OP_IF_KEEP: begin
        raw_exec = f_if_mask(exec_cur, cond);
        raw_wb   = exec_cur;
        exec_en  = 1'b1;
        wb_en    = 1'b1;
      end
      OP_ELSE: begin
        raw_exec = f_else_mask(exec_cur, saved);
        raw_wb   = exec_cur;
        exec_en  = 1'b1;
        wb_en    = 1'b1;
      end
      OP_REJOIN: begin
        raw_exec = f_rejoin(exec_cur, saved);
        exec_en  = 1'b1;
      end
      OP_EXIT: begin
        raw_wb   = f_exit(exec_cur, cond, saved, premasked);
        wb_en    = 1'b1;
      end
      OP_LOOP: begin
        raw_exec = f_loop(exec_cur, saved);
        exec_en  = 1'b1;
      end
      default: begin
        raw_exec = exec_cur;
      end
    endcase
  end

  assign exec_nxt = (raw_exec & win) | (exec_cur & ~win);
  assign wb_val   = raw_wb & win;

endmodule

// File: rtl/emask_exec_reg.sv
module emask_exec_reg #(
  parameter int LANES  = 64,
  parameter int NARROW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             narrow,
  input  logic [LANES-1:0] exec_nxt,
  output logic [LANES-1:0] exec_q,
  output logic             empty_q,
  output logic             nonempty_q
);

  logic any_active;

  assign any_active = narrow ? (|exec_nxt[NARROW-1:0]) : (|exec_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_q     <= '1;
      empty_q    <= 1'b0;
      nonempty_q <= 1'b1;
    end else if (load) begin
      exec_q     <= exec_nxt;
      empty_q    <= !any_active;
      nonempty_q <= any_active;
    end
  end

endmodule

// File: rtl/emask_unit.sv
module emask_unit
  import emask_pkg::*;
#(
  parameter int LANES   = DEF_LANES,
  parameter int NARROW  = DEF_NARROW,
  parameter int ENTRIES = DEF_ENTRIES,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_narrow,
  input  logic             cond_premasked,
  input  logic [LANES-1:0] cond,
  input  logic [IDXW-1:0]  rd_idx,
  input  logic [IDXW-1:0]  wr_idx,
  output logic [LANES-1:0] exec_mask,
  output logic             wb_valid,
  output logic [LANES-1:0] wb_data,
  output logic             br_empty,
  output logic             br_nonempty
);

  mask_op_e         op_dec;
  logic [LANES-1:0] saved_rd;
  logic [LANES-1:0] exec_nxt;
  logic [LANES-1:0] wb_val;
  logic             alu_exec_en;
  logic             alu_wb_en;
  logic             exec_load;
  logic             rf_we;

  assign op_dec    = mask_op_e'(cmd_op);
  assign exec_load = cmd_valid && alu_exec_en;
  assign rf_we     = cmd_valid && alu_wb_en;

  emask_sgrf #(.ENTRIES(ENTRIES), .WIDTH(LANES)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (wr_idx),
    .wdata (wb_val),
    .raddr (rd_idx),
    .rdata (saved_rd)
  );

  emask_alu #(.LANES(LANES), .NARROW(NARROW)) u_alu (
    .op        (op_dec),
    .narrow    (cmd_narrow),
    .premasked (cond_premasked),
    .exec_cur  (exec_mask),
    .cond      (cond),
    .saved     (saved_rd),
    .exec_nxt  (exec_nxt),
    .exec_en   (alu_exec_en),
    .wb_val    (wb_val),
    .wb_en     (alu_wb_en)
  );

  emask_exec_reg #(.LANES(LANES), .NARROW(NARROW)) u_exec (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (exec_load),
    .narrow     (cmd_narrow),
    .exec_nxt   (exec_nxt),
    .exec_q     (exec_mask),
    .empty_q    (br_empty),
    .nonempty_q (br_nonempty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_data  <= '0;
    end else begin
      wb_valid <= rf_we;
      if (rf_we) wb_data <= wb_val;
    end
  end

endmodule

// File: rtl/emask_unit_chk.sv
module emask_unit_chk
  import emask_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int NARROW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic             cmd_narrow,
  input logic [LANES-1:0] exec_mask,
  input logic             wb_valid,
  input logic [LANES-1:0] wb_data,
  input logic             br_empty,
  input logic             br_nonempty,
  input logic             exec_load,
  input logic             rf_we
);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    br_empty != br_nonempty); // R8

  AST_IDLE_HOLDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(exec_mask)); // R10

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !wb_valid); // R10

  AST_WB_FOLLOWS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> wb_valid); // R11

  AST_IF_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_IF) |=> ((exec_mask & ~$past(exec_mask)) == '0)); // R2

  AST_REJOIN_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_REJOIN) |=> ((~exec_mask & $past(exec_mask)) == '0)); // R5

  AST_EXIT_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_EXIT) |=> $stable(exec_mask)); // R6

  AST_LOOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_LOOP && !cmd_narrow) |=> (br_nonempty == (exec_mask != '0))); // R7

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_narrow) |=>
      (exec_mask[LANES-1:NARROW] == $past(exec_mask[LANES-1:NARROW]))); // R9

  AST_NARROW_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && cmd_narrow) |=> (wb_data[LANES-1:NARROW] == '0)); // R9

  AST_LOAD_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> !exec_load); // R10

endmodule

bind emask_unit emask_unit_chk #(.LANES(LANES), .NARROW(NARROW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_narrow  (cmd_narrow),
  .exec_mask   (exec_mask),
  .wb_valid    (wb_valid),
  .wb_data     (wb_data),
  .br_empty    (br_empty),
  .br_nonempty (br_nonempty),
  .exec_load   (exec_load),
  .rf_we       (rf_we)
);

// File: tb/tb_emask_unit.sv
module tb_emask_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic        cmd_narrow = 1'b0;
  logic        cond_premasked = 1'b0;
  logic [63:0] cond = '0;
  logic [3:0]  rd_idx = '0;
  logic [3:0]  wr_idx = '0;
  logic [63:0] exec_mask;
  logic        wb_valid;
  logic [63:0] wb_data;
  logic        br_empty;
  logic        br_nonempty;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [63:0] m_exec;
  logic [63:0] m_rf [16];
  logic        m_empty;

  always #2 clk = ~clk;

  emask_unit dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_narrow(cmd_narrow), .cond_premasked(cond_premasked), .cond(cond),
    .rd_idx(rd_idx), .wr_idx(wr_idx), .exec_mask(exec_mask), .wb_valid(wb_valid),
    .wb_data(wb_data), .br_empty(br_empty), .br_nonempty(br_nonempty)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Reference model, one 32-lane half at a time.
  task automatic issue(input string req, input logic v, input logic [2:0] op,
                       input logic nar, input logic pm, input logic [63:0] c,
                       input int rs, input int wd);
    logic [63:0] e, s, ne, w;
    logic        wr, ld;
    e = m_exec; s = m_rf[rs]; ne = e; w = '0; wr = 0; ld = 0;
    for (int h = 0; h < 2; h++) begin
      logic [31:0] eh, ch, sh;
      eh = e[h*32 +: 32]; ch = c[h*32 +: 32]; sh = s[h*32 +: 32];
      if (!(nar && h == 1)) begin
        case (op)
          3'd1: begin ne[h*32 +: 32] = eh & ch; w[h*32 +: 32] = eh & ~ch; end
          3'd2: begin ne[h*32 +: 32] = eh & ch; w[h*32 +: 32] = eh; end
          3'd3: begin ne[h*32 +: 32] = sh & ~eh; w[h*32 +: 32] = eh; end
          3'd4: ne[h*32 +: 32] = eh | sh;
          3'd5: w[h*32 +: 32] = pm ? (sh | ch) : (sh | (eh & ch));
          3'd6: ne[h*32 +: 32] = eh & ~sh;
          default: ;
        endcase
      end
    end
    wr = v && (op inside {3'd1, 3'd2, 3'd3, 3'd5});
    ld = v && (op inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd6});
    cmd_valid = v; cmd_op = op; cmd_narrow = nar; cond_premasked = pm;
    cond = c; rd_idx = 4'(rs); wr_idx = 4'(wd);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (ld) begin
      m_exec  = ne;
      m_empty = nar ? (ne[31:0] == 0) : (ne == 0);
    end
    if (wr) m_rf[wd] = w;
    check({req, " mask"}, exec_mask, m_exec);
    check({req, " empty flag"}, 64'(br_empty), 64'(m_empty));
    check({req, " nonempty flag"}, 64'(br_nonempty), 64'(!m_empty));
    check({req, " wb_valid"}, 64'(wb_valid), 64'(wr));
    if (wr) check({req, " wb_data"}, wb_data, w);
  endtask

  task automatic t_reset;
    check("R1 reset mask", exec_mask, '1);
    check("R1 reset empty", 64'(br_empty), 64'd0);
    check("R1 reset nonempty", 64'(br_nonempty), 64'd1);
    check("R1 reset wb_valid", 64'(wb_valid), 64'd0);
    issue("R2 narrow first", 1, 3'd1, 0, 0, 64'h0000_FFFF_0000_FFFF, 0, 1);
    issue("R1 unwritten entry rejoin", 1, 3'd4, 0, 0, '0, 9, 0);
    check("R1 entry 9 zero leaves mask", exec_mask, 64'h0000_FFFF_0000_FFFF);
    issue("R5 rejoin restore", 1, 3'd4, 0, 0, '0, 1, 0);
    check("R5 restored all ones", exec_mask, '1);
  endtask

  task automatic t_if_else;
    issue("R2 if", 1, 3'd1, 0, 0, 64'hF0F0_1234_AAAA_0001, 0, 2);
    issue("R2 nested if", 1, 3'd1, 0, 0, 64'h00FF_00FF_FFFF_FFFF, 0, 3);
    issue("R5 nested rejoin", 1, 3'd4, 0, 0, '0, 3, 0);
    issue("R4 else", 1, 3'd3, 0, 0, '0, 2, 2);
    check("R4 else lanes", exec_mask, ~64'hF0F0_1234_AAAA_0001);
    issue("R5 endif", 1, 3'd4, 0, 0, '0, 2, 0);
    check("R5 endif all ones", exec_mask, '1);
    issue("R8 if empty", 1, 3'd1, 0, 0, '0, 0, 4);
    check("R8 empty set", 64'(br_empty), 64'd1);
    issue("R8 else after empty", 1, 3'd3, 0, 0, '0, 4, 4);
    issue("R5 endif after empty", 1, 3'd4, 0, 0, '0, 4, 0);
  endtask

  task automatic t_keep_if;
    issue("R3 keep-all if", 1, 3'd2, 0, 0, 64'h8000_0000_0000_00FF, 0, 5);
    check("R3 saved full mask", wb_data, '1);
    issue("R11 reread after write", 1, 3'd4, 0, 0, '0, 5, 0);
  endtask

  task automatic t_loop;
    issue("R6 exit acc", 1, 3'd5, 0, 0, 64'h0000_0000_0000_000F, 0, 6);
    issue("R7 loop back", 1, 3'd6, 0, 0, '0, 6, 0);
    issue("R6 exit premasked", 1, 3'd5, 0, 1, 64'hFFFF_FFFF_0000_0003, 6, 6);
    issue("R7 loop back 2", 1, 3'd6, 0, 0, '0, 6, 0);
    issue("R6 exit rest", 1, 3'd5, 0, 0, '1, 6, 6);
    issue("R7 loop exits", 1, 3'd6, 0, 0, '0, 6, 0);
    check("R7 loop not taken", 64'(br_nonempty), 64'd0);
    issue("R5 loop rejoin", 1, 3'd4, 0, 0, '0, 6, 0);
  endtask

  task automatic t_narrow;
    issue("R9 narrow if zero", 1, 3'd1, 1, 0, 64'hFFFF_FFFF_0000_0000, 0, 7);
    check("R9 upper kept", exec_mask, 64'hFFFF_FFFF_0000_0000);
    check("R9 empty on low half", 64'(br_empty), 64'd1);
    issue("R9 narrow rejoin", 1, 3'd4, 1, 0, '0, 7, 0);
    issue("R9 narrow keep-all", 1, 3'd2, 1, 0, 64'h0000_0000_5555_5555, 0, 8);
    issue("R9 wide rejoin", 1, 3'd4, 0, 0, '0, 8, 0);
  endtask

  task automatic t_idle;
    issue("R10 setup", 1, 3'd1, 0, 0, 64'h0F0F_0F0F_0F0F_0F0F, 0, 10);
    issue("R10 invalid if", 0, 3'd1, 0, 0, '0, 0, 10);
    issue("R10 invalid rejoin", 0, 3'd4, 0, 0, '0, 10, 0);
    issue("R10 reserved op", 1, 3'd7, 0, 0, '0, 10, 10);
    issue("R10 idle op", 1, 3'd0, 0, 0, '0, 10, 10);
    issue("R10 entry intact", 1, 3'd4, 0, 0, '0, 10, 0);
    check("R10 mask restored", exec_mask, '1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_rf[i] = '0;
    m_exec = '1; m_empty = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_if_else;
    t_keep_if;
    t_loop;
    t_narrow;
    t_idle;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule